// File: doc/BRIEF.md
# Three-Level Page Table Walker

This block turns a 39-bit virtual address into a physical address by walking a three-level translation tree in memory. A requester (normally the TLB refill logic) offers one virtual address at a time through a valid/ready handshake. The walker takes the root page number and the paging mode from a 64-bit translation control word. It then issues one 64-bit read per level, starting at the top level. Each returned entry either points to the next table, ends the walk as a leaf, or aborts it.

The result comes back as a one-cycle response carrying the physical address and a fault flag. A fault also latches a cause bit and the faulting virtual address in two status outputs. A later successful walk clears the cause bit. When paging is switched off, the address passes straight through without any memory traffic. The walker never allocates tables or pages; a fault is only reported.

Top module: `pt_walker`

## Requirements
- R1: During and right after reset, `req_ready_o` is 1, `resp_valid_o` and `mem_req_valid_o` are 0, and `cause_o` and `tval_o` are all zeros.
- R2: With the mode field `ctrl_i[63:60]` equal to 0, an accepted request produces `resp_valid_o` in the next cycle. It carries `resp_paddr_o` equal to the zero-extended virtual address and `resp_fault_o` low. No memory read is issued and `cause_o`/`tval_o` keep their values.
- R3: With mode 8, the first read address is `ctrl_i[43:0]` shifted left by 12 plus `va[38:30]` times 8. Later reads use `va[29:21]`, then `va[20:12]`, each with the page number taken from bits [51:8] of the previous entry. Bits [59:44] of `ctrl_i` have no effect.
- R4: While `mem_req_valid_o` is high and `mem_req_ready_i` is low, the request stays valid and `mem_req_addr_o` stays unchanged.
- R5: An entry with bit 0 set and any of bits [3:1] set is a leaf at any level. The response has `resp_paddr_o` = entry bits [51:8] shifted left by 12, ORed with `va[11:0]`, and `resp_fault_o` low, one cycle after the data beat.
- R6: An entry with bit 0 clear ends the walk with a fault, whatever its other bits hold. No further read is issued and `resp_paddr_o` is 0.
- R7: A valid non-leaf entry read at the lowest level produces a fault.
- R8: On any fault response, bit 12 of `cause_o` is set, all other cause bits stay 0, and `tval_o` holds the zero-extended faulting virtual address.
- R9: A walk that ends in a leaf clears bit 12 of `cause_o` and leaves `tval_o` unchanged.
- R10: `req_ready_o` is low from the cycle after a request is accepted until after the response cycle. `resp_valid_o` is high for exactly one cycle per request.
- R11: A mode field other than 0 or 8 gives a fault response in the next cycle, with no memory read, and updates cause and trap value as in R8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctrl_i | input | 64 | Translation control: mode in [63:60], root page number in [43:0] |
| req_valid_i | input | 1 | Translation request offered |
| req_ready_o | output | 1 | Walker idle and able to accept |
| req_vaddr_i | input | 39 | Virtual address to translate |
| resp_valid_o | output | 1 | One-cycle response strobe |
| resp_paddr_o | output | 56 | Translated physical address (0 on fault) |
| resp_fault_o | output | 1 | Walk ended in a page fault |
| mem_req_valid_o | output | 1 | Entry read request |
| mem_req_ready_i | input | 1 | Memory accepts the read |
| mem_req_addr_o | output | 56 | Byte address of the entry |
| mem_rsp_valid_i | input | 1 | Read data beat |
| mem_rsp_data_i | input | 64 | Entry contents |
| cause_o | output | 64 | Cause status, bit 12 flags a page fault |
| tval_o | output | 64 | Faulting virtual address |

## Verification
The bench builds the walker with its default parameters: a 39-bit virtual address split into three 9-bit indices over a 12-bit offset, a 44-bit root number, entry page numbers from bit 8, and the fault flag at cause bit 12. With these values a small sparse table reaches every walk ending: a leaf at the middle or the lowest level, an invalid entry at the top or middle level, and a pointer found at the lowest level. The memory model alternates its ready signal and varies its read latency from zero to two cycles. This places the held-request path and back-to-back walks at several phases.

// File: rtl/ptw_pkg.sv
`timescale 1ns/1ps
package ptw_pkg;

   typedef enum logic [1:0] {
      ST_IDLE    = 2'd0,
      ST_RD_REQ  = 2'd1,
      ST_RD_WAIT = 2'd2,
      ST_RESP    = 2'd3
   } ptw_state_e;

   typedef enum logic [1:0] {
      STEP_DESCEND = 2'd0,
      STEP_LEAF    = 2'd1,
      STEP_FAULT   = 2'd2
   } ptw_step_e;

endpackage

// File: rtl/ptw_index_sel.sv
`timescale 1ns/1ps
module ptw_index_sel #(
   parameter int VA_W   = 39,
   parameter int OFF_W  = 12,
   parameter int IDX_W  = 9,
   parameter int LEVELS = 3,
   parameter int LVL_W  = 2
) (
   input  logic [VA_W-1:0]  va_i,
   input  logic [LVL_W-1:0] lvl_i,
   output logic [IDX_W-1:0] idx_o
);

   logic [IDX_W-1:0] field [LEVELS];

   for (genvar g = 0; g < LEVELS; g++) begin : g_field
      assign field[g] = va_i[OFF_W + g*IDX_W +: IDX_W];
   end

   logic unused_va_off;
   assign unused_va_off = ^va_i[OFF_W-1:0];

   always_comb begin
      idx_o = '0;
      for (int l = 0; l < LEVELS; l++) begin
         if (lvl_i == l[LVL_W-1:0]) idx_o = field[l];
      end
   end

endmodule

// File: rtl/ptw_entry_addr.sv
`timescale 1ns/1ps
module ptw_entry_addr #(
   parameter int PPN_W = 44,
   parameter int OFF_W = 12,
   parameter int IDX_W = 9,
   parameter int PA_W  = 56,
   parameter int PTE_W = 64
) (
   input  logic [PPN_W-1:0] ppn_i,
   input  logic [IDX_W-1:0] idx_i,
   output logic [PA_W-1:0]  addr_o
);

   localparam int ENTRY_LG = $clog2(PTE_W / 8);
   localparam int PAD_W    = PA_W - IDX_W - ENTRY_LG;

   logic [PA_W-1:0] table_base;
   logic [PA_W-1:0] entry_off;

   assign table_base = {ppn_i, {OFF_W{1'b0}}};
   assign entry_off  = {{PAD_W{1'b0}}, idx_i, {ENTRY_LG{1'b0}}};
   assign addr_o     = table_base + entry_off;

endmodule

// File: rtl/ptw_pte_decode.sv
`timescale 1ns/1ps
module ptw_pte_decode import ptw_pkg::*; #(
   parameter int PTE_W    = 64,
   parameter int PPN_W    = 44,
   parameter int PPN_LSB  = 8,
   parameter int PERM_LSB = 1,
   parameter int PERM_W   = 3
) (
   input  logic [PTE_W-1:0] pte_i,
   input  logic             last_lvl_i,
   output logic [PPN_W-1:0] ppn_o,
   output ptw_step_e        step_o
);

   logic valid_bit;
   logic leaf_bit;
   logic unused_pte;

   assign valid_bit  = pte_i[0];
   assign leaf_bit   = |pte_i[PERM_LSB +: PERM_W];
   assign ppn_o      = pte_i[PPN_LSB +: PPN_W];
   assign unused_pte = ^pte_i;

   always_comb begin
      if (!valid_bit)      step_o = STEP_FAULT;
      else if (leaf_bit)   step_o = STEP_LEAF;
      else if (last_lvl_i) step_o = STEP_FAULT;
      else                 step_o = STEP_DESCEND;
   end

endmodule

// File: rtl/ptw_fault_regs.sv
`timescale 1ns/1ps
module ptw_fault_regs #(
   parameter int CAUSE_W   = 64,
   parameter int CAUSE_BIT = 12,
   parameter int TVAL_W    = 64
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              set_i,
   input  logic              clr_i,
   input  logic [TVAL_W-1:0] tval_i,
   output logic [CAUSE_W-1:0] cause_o,
   output logic [TVAL_W-1:0] tval_o
);

   logic pf_flag_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         pf_flag_q <= 1'b0;
         tval_o    <= '0;
      end else if (set_i) begin
         pf_flag_q <= 1'b1;
         tval_o    <= tval_i;
      end else if (clr_i) begin
         pf_flag_q <= 1'b0;
      end
   end

   for (genvar b = 0; b < CAUSE_W; b++) begin : g_cause
      if (b == CAUSE_BIT) begin : g_flag
         assign cause_o[b] = pf_flag_q;
      end else begin : g_zero
         assign cause_o[b] = 1'b0;
      end
   end

   assert_set_loads_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_i |=> cause_o[CAUSE_BIT] && (tval_o == $past(tval_i)));

   assert_clear_keeps_tval_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_i && !set_i) |=> !cause_o[CAUSE_BIT] && $stable(tval_o));

endmodule

// File: rtl/pt_walker.sv
`timescale 1ns/1ps
module pt_walker import ptw_pkg::*; #(
   parameter int VA_W      = 39,
   parameter int PA_W      = 56,
   parameter int CTRL_W    = 64,
   parameter int PTE_W     = 64,
   parameter int LEVELS    = 3,
   parameter int IDX_W     = 9,
   parameter int OFF_W     = 12,
   parameter int PPN_W     = 44,
   parameter int PPN_LSB   = 8,
   parameter int MODE_W    = 4,
   parameter logic [MODE_W-1:0] MODE_BARE  = MODE_W'(0),
   parameter logic [MODE_W-1:0] MODE_PAGED = MODE_W'(8),
   parameter int CAUSE_W   = 64,
   parameter int CAUSE_BIT = 12,
   parameter int TVAL_W    = 64
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic [CTRL_W-1:0]  ctrl_i,
   input  logic               req_valid_i,
   output logic               req_ready_o,
   input  logic [VA_W-1:0]    req_vaddr_i,
   output logic               resp_valid_o,
   output logic [PA_W-1:0]    resp_paddr_o,
   output logic               resp_fault_o,
   output logic               mem_req_valid_o,
   input  logic               mem_req_ready_i,
   output logic [PA_W-1:0]    mem_req_addr_o,
   input  logic               mem_rsp_valid_i,
   input  logic [PTE_W-1:0]   mem_rsp_data_i,
   output logic [CAUSE_W-1:0] cause_o,
   output logic [TVAL_W-1:0]  tval_o
);

   localparam int LVL_W = (LEVELS > 1) ? $clog2(LEVELS) : 1;
   localparam logic [LVL_W-1:0] TOP_LVL = LVL_W'(LEVELS - 1);

   if (VA_W != OFF_W + LEVELS * IDX_W) begin : g_bad_va
      $error("VA_W must equal OFF_W + LEVELS*IDX_W");
   end
   if (PA_W != PPN_W + OFF_W) begin : g_bad_pa
      $error("PA_W must equal PPN_W + OFF_W");
   end
   if (PA_W <= VA_W) begin : g_bad_bare
      $error("PA_W must exceed VA_W");
   end
   if (CAUSE_BIT >= CAUSE_W) begin : g_bad_cause
      $error("CAUSE_BIT outside cause register");
   end
   if (TVAL_W <= VA_W) begin : g_bad_tval
      $error("TVAL_W must exceed VA_W");
   end
   if (CTRL_W < MODE_W + PPN_W) begin : g_bad_ctrl
      $error("control word too narrow");
   end
   if (PPN_LSB + PPN_W > PTE_W) begin : g_bad_pte
      $error("page number field outside entry");
   end

   ptw_state_e       state_q;
   logic [VA_W-1:0]  va_q;
   logic [PPN_W-1:0] ppn_q;
   logic [LVL_W-1:0] lvl_q;
   logic [PA_W-1:0]  pa_q;
   logic             fault_q;

   logic [MODE_W-1:0] mode;
   logic [PPN_W-1:0]  root_ppn;
   logic              is_bare, is_paged, accept, rsp_take;
   logic              set_fault, clr_fault;
   logic [TVAL_W-1:0] fault_va;
   logic [IDX_W-1:0]  cur_idx;
   logic [PPN_W-1:0]  pte_ppn;
   ptw_step_e         step;
   logic              unused_ctrl;

   assign mode        = ctrl_i[CTRL_W-1 -: MODE_W];
   assign root_ppn    = ctrl_i[PPN_W-1:0];
   assign unused_ctrl = ^ctrl_i;
   assign is_bare     = (mode == MODE_BARE);
   assign is_paged    = (mode == MODE_PAGED);
   assign accept      = (state_q == ST_IDLE) && req_valid_i;
   assign rsp_take    = (state_q == ST_RD_WAIT) && mem_rsp_valid_i;
   assign set_fault   = (accept && !is_bare && !is_paged) ||
                        (rsp_take && step == STEP_FAULT);
   assign clr_fault   = rsp_take && step == STEP_LEAF;
   assign fault_va    = accept ? {{(TVAL_W-VA_W){1'b0}}, req_vaddr_i}
                               : {{(TVAL_W-VA_W){1'b0}}, va_q};

   assign req_ready_o     = (state_q == ST_IDLE);
   assign mem_req_valid_o = (state_q == ST_RD_REQ);
   assign resp_valid_o    = (state_q == ST_RESP);
   assign resp_paddr_o    = pa_q;
   assign resp_fault_o    = fault_q;

   ptw_index_sel #(
      .VA_W(VA_W), .OFF_W(OFF_W), .IDX_W(IDX_W), .LEVELS(LEVELS), .LVL_W(LVL_W)
   ) u_index_sel (
      .va_i(va_q), .lvl_i(lvl_q), .idx_o(cur_idx)
   );

   ptw_entry_addr #(
      .PPN_W(PPN_W), .OFF_W(OFF_W), .IDX_W(IDX_W), .PA_W(PA_W), .PTE_W(PTE_W)
   ) u_entry_addr (
      .ppn_i(ppn_q), .idx_i(cur_idx), .addr_o(mem_req_addr_o)
   );

   ptw_pte_decode #(
      .PTE_W(PTE_W), .PPN_W(PPN_W), .PPN_LSB(PPN_LSB), .PERM_LSB(1), .PERM_W(3)
   ) u_pte_decode (
      .pte_i(mem_rsp_data_i), .last_lvl_i(lvl_q == '0),
      .ppn_o(pte_ppn), .step_o(step)
   );

   ptw_fault_regs #(
      .CAUSE_W(CAUSE_W), .CAUSE_BIT(CAUSE_BIT), .TVAL_W(TVAL_W)
   ) u_fault_regs (
      .clk_i(clk_i), .rst_ni(rst_ni), .set_i(set_fault), .clr_i(clr_fault),
      .tval_i(fault_va), .cause_o(cause_o), .tval_o(tval_o)
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         state_q <= ST_IDLE;
         va_q    <= '0;
         ppn_q   <= '0;
         lvl_q   <= '0;
         pa_q    <= '0;
         fault_q <= 1'b0;
      end else begin
         case (state_q)
            ST_IDLE: begin
               if (req_valid_i) begin
                  va_q <= req_vaddr_i;
                  if (is_bare) begin
                     pa_q    <= {{(PA_W-VA_W){1'b0}}, req_vaddr_i};
                     fault_q <= 1'b0;
                     state_q <= ST_RESP;
                  end else if (is_paged) begin
                     ppn_q   <= root_ppn;
                     lvl_q   <= TOP_LVL;
                     state_q <= ST_RD_REQ;
                  end else begin
                     pa_q    <= '0;
                     fault_q <= 1'b1;
                     state_q <= ST_RESP;
                  end
               end
            end
            ST_RD_REQ: begin
               if (mem_req_ready_i) state_q <= ST_RD_WAIT;
            end
            ST_RD_WAIT: begin
               if (mem_rsp_valid_i) begin
                  case (step)
                     STEP_LEAF: begin
                        pa_q    <= {pte_ppn, va_q[OFF_W-1:0]};
                        fault_q <= 1'b0;
                        state_q <= ST_RESP;
                     end
                     STEP_DESCEND: begin
                        ppn_q   <= pte_ppn;
                        lvl_q   <= lvl_q - 1'b1;
                        state_q <= ST_RD_REQ;
                     end
                     default: begin
                        pa_q    <= '0;
                        fault_q <= 1'b1;
                        state_q <= ST_RESP;
                     end
                  endcase
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assert_req_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mem_req_valid_o && !mem_req_ready_i) |=> mem_req_valid_o && $stable(mem_req_addr_o));

   assert_busy_after_accept_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (req_valid_i && req_ready_o) |=> !req_ready_o);

   assert_resp_single_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      resp_valid_o |=> !resp_valid_o);

   assert_bare_passthru_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (req_valid_i && req_ready_o && is_bare) |=>
         resp_valid_o && !resp_fault_o &&
         resp_paddr_o == {{(PA_W-VA_W){1'b0}}, $past(req_vaddr_i)});

   assert_fault_cause_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (resp_valid_o && resp_fault_o) |-> cause_o[CAUSE_BIT] &&
         tval_o == {{(TVAL_W-VA_W){1'b0}}, va_q});

   assert_success_clears_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (resp_valid_o && !resp_fault_o && $past(state_q == ST_RD_WAIT)) |-> !cause_o[CAUSE_BIT]);

endmodule

// File: tb/pt_walker_bench.sv
`timescale 1ns/1ps
module pt_walker_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [63:0] ctrl = '0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [38:0] req_vaddr = '0;
   logic        resp_valid;
   logic [55:0] resp_paddr;
   logic        resp_fault;
   logic        mem_req_valid;
   logic        mem_req_ready = 1'b0;
   logic [55:0] mem_req_addr;
   logic        mem_rsp_valid = 1'b0;
   logic [63:0] mem_rsp_data = '0;
   logic [63:0] cause;
   logic [63:0] tval;

   always #2.5 clk = ~clk;

   pt_walker u_pt_walker (
      .clk_i(clk), .rst_ni(rst_n), .ctrl_i(ctrl),
      .req_valid_i(req_valid), .req_ready_o(req_ready), .req_vaddr_i(req_vaddr),
      .resp_valid_o(resp_valid), .resp_paddr_o(resp_paddr), .resp_fault_o(resp_fault),
      .mem_req_valid_o(mem_req_valid), .mem_req_ready_i(mem_req_ready),
      .mem_req_addr_o(mem_req_addr), .mem_rsp_valid_i(mem_rsp_valid),
      .mem_rsp_data_i(mem_rsp_data), .cause_o(cause), .tval_o(tval)
   );

   int          n_checks = 0;
   int          n_fail = 0;
   bit          done = 0;
   logic [63:0] mem [longint];
   longint      exp_q [$];
   int          handshakes = 0;
   bit          m_cause = 0;
   logic [63:0] m_tval = '0;

   int          cyc = 0;
   bit          pend = 0;
   int          wt = 0;
   longint      pend_addr = 0;
   bit          held_v = 0;
   logic [55:0] held_addr = '0;

   task automatic check(input bit ok, input string req, input logic [63:0] act,
                        input logic [63:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [63:0] rd(input longint a);
      return mem.exists(a) ? mem[a] : 64'h0;
   endfunction

   function automatic logic [38:0] mk_va(input int i2, input int i1, input int i0, input int off);
      return (39'(i2) << 30) | (39'(i1) << 21) | (39'(i0) << 12) | 39'(off);
   endfunction

   function automatic logic [63:0] mk_ctrl(input logic [3:0] md, input logic [15:0] junk,
                                           input logic [43:0] root);
      return {md, junk, root};
   endfunction

   // behavioural reference walk
   task automatic model(input logic [38:0] va, input logic [63:0] c,
                        output logic [55:0] pa, output bit flt);
      longint ppn, a;
      logic [63:0] pte;
      bit fin;
      pa = '0; flt = 0; fin = 0;
      if (c[63:60] == 4'd0) begin
         pa = {17'h0, va};
      end else if (c[63:60] != 4'd8) begin
         flt = 1;
      end else begin
         ppn = longint'(c[43:0]);
         for (int lvl = 2; lvl >= 0 && !fin; lvl--) begin
            a = ppn * 4096 + longint'((va >> (12 + 9*lvl)) & 39'h1FF) * 8;
            exp_q.push_back(a);
            pte = rd(a);
            if (!pte[0]) begin flt = 1; fin = 1; end
            else if (|pte[3:1]) begin pa = {pte[51:8], va[11:0]}; fin = 1; end
            else if (lvl == 0) begin flt = 1; fin = 1; end
            else ppn = longint'(pte[51:8]);
         end
      end
      if (flt) begin m_cause = 1; m_tval = {25'h0, va}; end
      else if (c[63:60] == 4'd8) m_cause = 0;
   endtask

   // memory responder: ready pattern and 0..2 cycle latency
   always @(negedge clk) begin
      cyc++;
      mem_rsp_valid = 1'b0;
      if (pend) begin
         if (wt == 0) begin
            mem_rsp_valid = 1'b1;
            mem_rsp_data  = rd(pend_addr);
            pend = 0;
         end else wt--;
      end
      if (held_v && mem_req_valid)
         check(mem_req_addr == held_addr, "R4 held address", 64'(mem_req_addr), 64'(held_addr));
      held_v = 0;
      mem_req_ready = (cyc % 4 != 1);
      if (mem_req_valid && mem_req_ready) begin
         handshakes++;
         if (exp_q.size() == 0) check(0, "R3 unexpected read", 64'(mem_req_addr), 64'h0);
         else begin
            longint e;
            e = exp_q.pop_front();
            check(longint'(mem_req_addr) == e, "R3 read address", 64'(mem_req_addr), 64'(e));
         end
         pend = 1; wt = cyc % 3; pend_addr = longint'(mem_req_addr);
      end else if (mem_req_valid) begin
         held_v = 1; held_addr = mem_req_addr;
      end
   end

   task automatic run_walk(input logic [38:0] va, input logic [63:0] c, input string tag);
      logic [55:0] epa;
      bit ef;
      int hs0;
      bit seen;
      model(va, c, epa, ef);
      hs0 = handshakes;
      seen = 0;
      check(req_ready, {"R10 idle ready ", tag}, 64'(req_ready), 64'h1);
      ctrl = c; req_vaddr = va; req_valid = 1'b1;
      @(posedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      for (int k = 0; k < 300; k++) begin
         check(!req_ready, {"R10 busy ", tag}, 64'(req_ready), 64'h0);
         if (resp_valid) begin seen = 1; break; end
         @(negedge clk);
      end
      check(seen, {"R10 response seen ", tag}, 64'(seen), 64'h1);
      check(resp_paddr == epa, {tag, " paddr"}, 64'(resp_paddr), 64'(epa));
      check(resp_fault == ef, {tag, " fault flag"}, 64'(resp_fault), 64'(ef));
      check(cause == (64'(m_cause) << 12), {"R8 R9 cause ", tag}, cause, 64'(m_cause) << 12);
      check(tval == m_tval, {"R8 R9 tval ", tag}, tval, m_tval);
      check(exp_q.size() == 0, {"R6 reads complete ", tag}, 64'(exp_q.size()), 64'h0);
      if (c[63:60] != 4'd8)
         check(handshakes == hs0, {"R2 R11 no read ", tag}, 64'(handshakes - hs0), 64'h0);
      @(negedge clk);
      check(!resp_valid && req_ready, {"R10 one-cycle response ", tag},
            {62'h0, resp_valid, req_ready}, 64'h1);
   endtask

   initial begin
      mem[(64'h100 << 12) + 3*8] = (64'h200 << 8) | 64'h1;
      mem[(64'h200 << 12) + 5*8] = (64'h300 << 8) | 64'h1;
      mem[(64'h300 << 12) + 7*8] = (64'h4567 << 8) | 64'hF;
      mem[(64'h200 << 12) + 6*8] = (64'h777 << 8) | 64'h3;
      mem[(64'h300 << 12) + 9*8] = (64'h555 << 8) | 64'h1;
      mem[(64'h200 << 12) + 8*8] = (64'h999 << 8) | 64'hE;

      repeat (3) @(negedge clk);
      check(req_ready && !resp_valid && !mem_req_valid, "R1 reset handshake outputs",
            {61'h0, req_ready, resp_valid, mem_req_valid}, 64'h4);
      check(cause == 64'h0 && tval == 64'h0, "R1 reset status", cause | tval, 64'h0);
      rst_n = 1'b1;
      @(negedge clk);
      check(req_ready && !resp_valid, "R1 after reset", {62'h0, req_ready, resp_valid}, 64'h2);

      run_walk(39'h12_3456_789A, mk_ctrl(4'd0, 16'h0, 44'h100), "R2 bare pass-through");
      run_walk(mk_va(3, 5, 7, 12'hABC), mk_ctrl(4'd8, 16'h0, 44'h100), "R5 R3 level-0 leaf");
      run_walk(mk_va(3, 6, 1, 12'h123), mk_ctrl(4'd8, 16'h0, 44'h100), "R5 level-1 leaf");
      run_walk(mk_va(9, 0, 0, 12'h010), mk_ctrl(4'd8, 16'h0, 44'h100), "R6 invalid top entry");
      run_walk(mk_va(3, 8, 2, 12'h777), mk_ctrl(4'd8, 16'h0, 44'h100), "R6 invalid with perms");
      run_walk(mk_va(3, 5, 7, 12'h001), mk_ctrl(4'd8, 16'h0, 44'h100), "R9 success clears");
      run_walk(mk_va(3, 5, 9, 12'hFFF), mk_ctrl(4'd8, 16'h0, 44'h100), "R7 pointer at level 0");
      run_walk(mk_va(3, 5, 7, 12'h0F0), mk_ctrl(4'd8, 16'hBEEF, 44'h100), "R3 upper ctrl bits");
      run_walk(mk_va(1, 2, 3, 12'h456), mk_ctrl(4'd5, 16'h0, 44'h100), "R11 illegal mode");
      run_walk(39'h00_0000_1234, mk_ctrl(4'd0, 16'h0, 44'h0), "R2 bare keeps status");
      for (int r = 0; r < 6; r++) begin
         run_walk(mk_va(3, 5, 7, 12'h100 + r), mk_ctrl(4'd8, 16'h0, 44'h100), "R4 R5 repeat");
         run_walk(mk_va(3, 6, r, 12'h200 + r), mk_ctrl(4'd8, 16'h0, 44'h100), "R5 repeat level-1");
      end

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog R10 actual=hung expected=finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

endmodule